// File: doc/BRIEF.md
# Signed-Magnitude Complex Vector Multiplier

This block multiplies a stream of complex samples, one element at a time, by a reference vector of complex coefficients. The coefficients are held in a local SRAM. It belongs in a frequency-domain matched filter, between the forward transform and the inverse transform. Each 32-bit word carries two 16-bit signed-magnitude fixed-point values. Each value has a sign bit, 7 integer bits and 8 fraction bits. The real part occupies bits [31:16] and the imaginary part bits [15:0].

Samples arrive on a valid/ready input. For each accepted sample the block reads the coefficient at the current vector index and computes `(a+jb)(c+jd) = (ac-bd) + j(ad+bc)` in two's complement at full precision. It then rounds and saturates each component back to the 16-bit signed-magnitude format. The product leaves on a valid/ready output after a fixed three-cycle pipeline. The coefficient index steps once per accepted sample and wraps at the vector length, so consecutive vectors line up with the same reference without any framing input.

Top module: `cvm_top`

## Requirements
- R1: The output word holds the complex product of the input sample and the coefficient, packed in the same format: real in [31:16], imaginary in [15:0], bit 15 of each half is the sign and bits [14:0] the magnitude in units of 1/256.
- R2: Each component is the full-precision result shifted right by 8 bits, rounded half away from zero; a magnitude remainder of exactly 128/256 rounds up in magnitude, a smaller remainder rounds down.
- R3: A component whose rounded magnitude exceeds 0x7FFF is output as magnitude 0x7FFF with its sign kept; a magnitude of exactly 0x7FFF passes unchanged.
- R4: An input half equal to 0x8000 (negative zero) is treated as zero, and the block never outputs 0x8000 in either half; a zero result is always 0x0000.
- R5: With out_ready held high, a sample presented with in_valid and in_ready in cycle t appears with out_valid in cycle t+3, and not earlier.
- R6: With out_ready held high, in_ready stays high and one sample is accepted and one product delivered per cycle.
- R7: While out_valid is high and out_ready low, out_data stays unchanged, in_ready is low, and no product is lost or repeated once the stall ends.
- R8: coef_rd_en is high exactly in the cycles in which a sample is accepted. The coefficient is taken from coef_rdata in the cycle that follows, and the SRAM must hold coef_rdata while coef_rd_en is low.
- R9: coef_addr is 0 for the first sample after reset and increases by one per accepted sample, going from VEC_LEN-1 back to 0.
- R10: During and directly after reset, out_valid is low, in_ready is high and coef_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 2*HALF_W | Complex sample, real high, imaginary low |
| coef_rd_en | output | 1 | Coefficient SRAM read strobe |
| coef_addr | output | $clog2(VEC_LEN) | Coefficient index within the vector |
| coef_rdata | input | 2*HALF_W | Coefficient word, one cycle after the strobe |
| out_valid | output | 1 | Product present |
| out_ready | input | 1 | Consumer takes the product |
| out_data | output | 2*HALF_W | Complex product, real high, imaginary low |

## Verification
If the coefficient index is off by one, products come out paired with the wrong coefficient from the very first sample, and the address checks show it after the first accept. A wrong stage enable under backpressure makes out_data change during a stall, or makes the scoreboard see a product dropped or repeated; both show within the cycle after out_ready returns. A sign or rounding fault only shows on certain operand patterns: negative zero, half-LSB remainders and magnitudes just at and just over 0x7FFF. The vector table drives each of these directly and checks the result three cycles later.

// File: rtl/cvm_pkg.sv
package cvm_pkg;
  localparam int DEF_HALF_W  = 16;
  localparam int DEF_FRAC_W  = 8;
  localparam int DEF_VEC_LEN = 1024;
endpackage

// File: rtl/cvm_coef_addr.sv
module cvm_coef_addr #(
  parameter int VEC_LEN = 1024,
  localparam int AW = $clog2(VEC_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(VEC_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (step) addr <= (addr == LAST) ? '0 : addr + 1'b1;
  end

  // R9
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> addr == (($past(addr) == LAST) ? '0 : $past(addr) + 1'b1));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(addr));
endmodule

// File: rtl/cvm_cplx_prod.sv
module cvm_cplx_prod #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int PW = 2 * HALF_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 v_in,
  input  logic [WORD_W-1:0]    samp,
  input  logic [WORD_W-1:0]    coef,
  output logic                 v_q,
  output logic signed [PW-1:0] p_ac,
  output logic signed [PW-1:0] p_bd,
  output logic signed [PW-1:0] p_ad,
  output logic signed [PW-1:0] p_bc
);
  function automatic logic signed [HALF_W:0] to_tc(input logic [HALF_W-1:0] x);
    logic signed [HALF_W:0] m;
    m = $signed({2'b00, x[HALF_W-2:0]});
    return x[HALF_W-1] ? -m : m;
  endfunction

  logic signed [HALF_W:0] a, b, c, d;

  always_comb begin
    a = to_tc(samp[WORD_W-1:HALF_W]);
    b = to_tc(samp[HALF_W-1:0]);
    c = to_tc(coef[WORD_W-1:HALF_W]);
    d = to_tc(coef[HALF_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst)     v_q <= 1'b0;
    else if (en) v_q <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      p_ac <= a * c;
      p_bd <= b * d;
      p_ad <= a * d;
      p_bc <= b * c;
    end
  end
endmodule

// File: rtl/cvm_round_sat.sv
module cvm_round_sat #(
  parameter int HALF_W = 16,
  parameter int FRAC_W = 8,
  parameter int ACC_W  = 35
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] acc,
  output logic [HALF_W-1:0]       res_q
);
  localparam int MW = HALF_W - 1;
  localparam logic [ACC_W:0] HALF_LSB = (ACC_W + 1)'(1) << (FRAC_W - 1);
  localparam logic [ACC_W:0] MAX_MAG  = (ACC_W + 1)'((1 << MW) - 1);

  logic          neg;
  logic [ACC_W:0] mag, rnd, shr;
  logic [MW-1:0]  mag_o;

  always_comb begin
    neg   = acc[ACC_W-1];
    mag   = {1'b0, neg ? -acc : acc};
    rnd   = mag + HALF_LSB;
    shr   = rnd >> FRAC_W;
    mag_o = (shr > MAX_MAG) ? '1 : shr[MW-1:0];
  end

  always_ff @(posedge clk) begin
    if (en) res_q <= {neg && (mag_o != '0), mag_o};
  end
endmodule

// File: rtl/cvm_top.sv
module cvm_top #(
  parameter int HALF_W  = cvm_pkg::DEF_HALF_W,
  parameter int FRAC_W  = cvm_pkg::DEF_FRAC_W,
  parameter int VEC_LEN = cvm_pkg::DEF_VEC_LEN,
  localparam int WORD_W = 2 * HALF_W,
  localparam int AW     = $clog2(VEC_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              coef_rd_en,
  output logic [AW-1:0]     coef_addr,
  input  logic [WORD_W-1:0] coef_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  localparam int PW    = 2 * HALF_W + 2;
  localparam int ACC_W = PW + 1;
  localparam logic [HALF_W-1:0] NEG_ZERO = {1'b1, {(HALF_W - 1){1'b0}}};

  logic              adv, accept;
  logic              s1_v, s2_v;
  logic [WORD_W-1:0] s1_data;
  logic signed [PW-1:0] p_ac, p_bd, p_ad, p_bc;
  logic signed [ACC_W-1:0] acc [2];
  logic [HALF_W-1:0] res [2];

  // whole pipe moves together; stall only when the output is held
  assign adv        = !out_valid || out_ready;
  assign in_ready   = adv;
  assign accept     = in_valid && adv;
  assign coef_rd_en = accept;

  cvm_coef_addr #(.VEC_LEN(VEC_LEN)) i_addr (
    .clk (clk), .rst (rst), .step (accept), .addr (coef_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)      s1_v <= 1'b0;
    else if (adv) s1_v <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) s1_data <= in_data;
  end

  // coefficient word arrives while the sample sits in stage 1
  cvm_cplx_prod #(.HALF_W(HALF_W)) i_prod (
    .clk (clk), .rst (rst), .en (adv), .v_in (s1_v),
    .samp (s1_data), .coef (coef_rdata), .v_q (s2_v),
    .p_ac (p_ac), .p_bd (p_bd), .p_ad (p_ad), .p_bc (p_bc)
  );

  assign acc[0] = {p_ac[PW-1], p_ac} - {p_bd[PW-1], p_bd};
  assign acc[1] = {p_ad[PW-1], p_ad} + {p_bc[PW-1], p_bc};

  for (genvar g = 0; g < 2; g++) begin : g_comp
    cvm_round_sat #(.HALF_W(HALF_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) i_rs (
      .clk (clk), .en (adv), .acc (acc[g]), .res_q (res[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)      out_valid <= 1'b0;
    else if (adv) out_valid <= s2_v;
  end

  assign out_data = {res[0], res[1]};

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R4
  no_neg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[WORD_W-1:HALF_W] != NEG_ZERO) && (out_data[HALF_W-1:0] != NEG_ZERO));
endmodule

// File: tb/test_cvm_top.sv
module test_cvm_top;
  localparam int VEC_LEN = 1024;
  localparam int AW = $clog2(VEC_LEN);

  typedef struct packed {
    logic [31:0] s;
    logic [31:0] c;
    logic [31:0] e;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{32'h0100_0000, 32'h0100_0000, 32'h0100_0000, 8'd1},  // R1 1*1
    '{32'h0100_0100, 32'h0100_8100, 32'h0200_0000, 8'd1},  // R1 (1+j)(1-j)=2
    '{32'h0000_0100, 32'h0000_0100, 32'h8100_0000, 8'd1},  // R1 j*j=-1
    '{32'h8000_8000, 32'h0100_0100, 32'h0000_0000, 8'd4},  // R4 negative zero input
    '{32'h0001_0000, 32'h0080_0000, 32'h0001_0000, 8'd2},  // R2 +half rounds up
    '{32'h8001_0000, 32'h0080_0000, 32'h8001_0000, 8'd2},  // R2 -half rounds away
    '{32'h8001_0000, 32'h007F_0000, 32'h0000_0000, 8'd4},  // R4 tiny negative -> +0
    '{32'h7FFF_0000, 32'h0200_0000, 32'h7FFF_0000, 8'd3},  // R3 positive saturation
    '{32'hFFFF_0000, 32'h0200_0000, 32'hFFFF_0000, 8'd3},  // R3 negative saturation
    '{32'h7FFF_0000, 32'h0100_0000, 32'h7FFF_0000, 8'd3},  // R3 exact maximum
    '{32'h0180_0200, 32'h8080_0040, 32'h8140_80A0, 8'd1},  // R1 mixed signs
    '{32'h0000_0200, 32'h0180_0000, 32'h0000_0300, 8'd1}   // R1 imaginary placement
  };

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready, coef_rd_en, out_valid, out_ready;
  logic [31:0] in_data, coef_rdata, out_data;
  logic [AW-1:0] coef_addr;
  logic [31:0] mem [VEC_LEN];

  int n_checks = 0;
  int n_err = 0;
  int n_pop = 0;
  int exp_addr = 0;
  logic [31:0] exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (coef_rd_en) coef_rdata <= mem[coef_addr];
  end

  cvm_top #(.VEC_LEN(VEC_LEN)) i_cvm_top (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
    .in_data (in_data), .coef_rd_en (coef_rd_en), .coef_addr (coef_addr),
    .coef_rdata (coef_rdata), .out_valid (out_valid), .out_ready (out_ready),
    .out_data (out_data)
  );

  function automatic longint smv(input logic [15:0] x);
    longint m;
    m = longint'(x[14:0]);
    return x[15] ? -m : m;
  endfunction

  function automatic logic [15:0] pack(input longint v);
    longint m;
    m = (v < 0) ? -v : v;
    m = (m + 128) / 256;
    if (m > 32767) m = 32767;
    return {(v < 0) && (m != 0), 15'(m)};
  endfunction

  function automatic logic [31:0] ref_mul(input logic [31:0] s, input logic [31:0] c);
    longint a, b, cr, ci;
    a = smv(s[31:16]); b = smv(s[15:0]);
    cr = smv(c[31:16]); ci = smv(c[15:0]);
    return {pack(a * cr - b * ci), pack(a * ci + b * cr)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic iv, input logic [31:0] d, input logic ordy,
                      input bit use_t, input logic [31:0] texp, input string tag,
                      output logic acc);
    logic [31:0] e;
    string t;
    @(negedge clk);
    in_valid = iv; in_data = d; out_ready = ordy;
    #1;
    if (out_valid && out_ready) begin
      n_pop++;
      if (exp_q.size() == 0) chk(1'b0, "R7 extra output", out_data, 32'h0);
      else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(out_data == e, t, out_data, e);
      end
    end
    acc = in_valid && in_ready;
    if (acc) begin
      chk(coef_rd_en == 1'b1, "R8 read strobe on accept", 32'(coef_rd_en), 32'h1);
      chk(32'(coef_addr) == 32'(exp_addr), "R9 coefficient index", 32'(coef_addr), 32'(exp_addr));
      exp_q.push_back(use_t ? texp : ref_mul(d, mem[exp_addr]));
      tag_q.push_back(tag);
      exp_addr = (exp_addr == VEC_LEN - 1) ? 0 : exp_addr + 1;
    end else begin
      chk(coef_rd_en == 1'b0, "R8 no read without accept", 32'(coef_rd_en), 32'h0);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL R6 watchdog got timeout exp completion");
    summary();
    $finish;
  end

  initial begin
    logic a;
    logic [31:0] held;
    int cnt;
    for (int i = 0; i < VEC_LEN; i++) mem[i] = $urandom;
    for (int k = 0; k < NV; k++) mem[k] = TBL[k].c;
    rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R10 during reset
    chk(out_valid == 1'b0, "R10 out_valid in reset", 32'(out_valid), 32'h0);
    chk(in_ready == 1'b1, "R10 in_ready in reset", 32'(in_ready), 32'h1);
    rst = 1'b0;
    @(negedge clk);
    // R10 after reset
    chk(out_valid == 1'b0, "R10 out_valid after reset", 32'(out_valid), 32'h0);
    chk(32'(coef_addr) == 0, "R10 coef_addr after reset", 32'(coef_addr), 32'h0);

    // vector table: R1 R2 R3 R4
    for (int k = 0; k < NV; k++)
      step(1'b1, TBL[k].s, 1'b1, 1'b1, TBL[k].e, $sformatf("R%0d table %0d", TBL[k].req, k), a);
    repeat (5) step(1'b0, 32'h0, 1'b1, 1'b0, 32'h0, "", a);
    chk(exp_q.size() == 0, "R1 table drained", 32'(exp_q.size()), 32'h0);

    // R5 latency: single sample, output exactly in cycle t+3
    step(1'b1, 32'h0100_0100, 1'b1, 1'b0, 32'h0, "R5 data", a);
    step(1'b0, 32'h0, 1'b1, 1'b0, 32'h0, "", a);
    chk(out_valid == 1'b0, "R5 not at t+1", 32'(out_valid), 32'h0);
    step(1'b0, 32'h0, 1'b1, 1'b0, 32'h0, "", a);
    chk(out_valid == 1'b0, "R5 not at t+2", 32'(out_valid), 32'h0);
    step(1'b0, 32'h0, 1'b1, 1'b0, 32'h0, "", a);
    chk(out_valid == 1'b1, "R5 valid at t+3", 32'(out_valid), 32'h1);
    repeat (2) step(1'b0, 32'h0, 1'b1, 1'b0, 32'h0, "", a);

    // R6 full rate
    cnt = n_pop;
    for (int i = 0; i < 24; i++) begin
      step(1'b1, $urandom, 1'b1, 1'b0, 32'h0, "R6 stream data", a);
      chk(a == 1'b1, "R6 accepted every cycle", 32'(a), 32'h1);
    end
    repeat (3) step(1'b0, 32'h0, 1'b1, 1'b0, 32'h0, "", a);
    chk(n_pop - cnt == 24, "R6 one product per cycle", 32'(n_pop - cnt), 32'd24);

    // R7 mixed backpressure
    for (int i = 0; i < 60; i++)
      step((i % 5) != 2, $urandom, (i % 4) != 1, 1'b0, 32'h0, "R7 backpressure data", a);
    repeat (6) step(1'b0, 32'h0, 1'b1, 1'b0, 32'h0, "", a);
    chk(exp_q.size() == 0, "R7 no loss after backpressure", 32'(exp_q.size()), 32'h0);

    // R7 long stall: held output, no accept, no read
    repeat (3) step(1'b1, $urandom, 1'b1, 1'b0, 32'h0, "R7 stall data", a);
    step(1'b1, 32'h1234_5678, 1'b0, 1'b0, 32'h0, "R7 stall data", a);
    held = out_data;
    chk(out_valid == 1'b1, "R7 output pending", 32'(out_valid), 32'h1);
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 32'h1234_5678, 1'b0, 1'b0, 32'h0, "R7 stall data", a);
      chk(a == 1'b0, "R7 in_ready low in stall", 32'(a), 32'h0);
      chk(out_data == held, "R7 out_data held", out_data, held);
    end
    repeat (6) step(1'b0, 32'h0, 1'b1, 1'b0, 32'h0, "", a);
    chk(exp_q.size() == 0, "R7 no loss after stall", 32'(exp_q.size()), 32'h0);

    // R9 wrap of the coefficient index across a full vector
    for (int i = 0; i < VEC_LEN + 40; i++)
      step(1'b1, $urandom, 1'b1, 1'b0, 32'h0, "R9 wrap data", a);
    repeat (5) step(1'b0, 32'h0, 1'b1, 1'b0, 32'h0, "", a);
    chk(exp_q.size() == 0, "R9 drained after wrap", 32'(exp_q.size()), 32'h0);

    summary();
    $finish;
  end
endmodule